// File: doc/BRIEF.md
# Programmable Page Permission Checker

This block decides whether one memory reference may proceed. Each request carries a page-present flag and a 4-bit access-class index taken from the page-table entry. It also carries the privilege mode that was fixed when the operation was decoded, the kind of access (read, write or instruction fetch) and an opaque tag. The access-class index selects one row of a 16-row permission table held in registers. The mode then selects one 3-bit permission group from that row. The block answers allow or fault, with a cause code, one cycle after it accepts the request.

Because the mode travels with each request, a change of privilege takes effect for individual operations without draining the pipeline. Software can rewrite any row of the table through a single-cycle write port, so the meaning of an access class can be redefined without touching page-table entries. Reset loads a hierarchical default in which a more privileged mode never has less access than a less privileged one.

Top module: `page_perm_check`

## Requirements
- R1: While `rst_n` is low, `req_ready` and `rsp_valid` are 0. From the first clock edge after reset is released, `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in exactly the cycle after an acceptance and 0 otherwise. `rsp_tag` equals the accepted `req_tag`.
- R3: If `req_present` is 0, the response faults with `rsp_cause` = 1 (absent), whatever the table holds.
- R4: Row bits [3m+2:3m] form the group for mode m (0 user, 1 supervisor, 2 executive, 3 kernel). Within a group, bit 0 permits read, bit 1 permits write and bit 2 permits fetch.
- R5: `req_kind` is 0 for read, 1 for write and 2 for fetch, and each checks its matching group bit. Kind 3 is always denied.
- R6: A present request whose selected bit is set answers `rsp_allow`=1, `rsp_fault`=0, `rsp_cause`=0. If the bit is clear it answers `rsp_allow`=0, `rsp_fault`=1, `rsp_cause`=2 (denied). When `rsp_valid` is 0, `rsp_allow` and `rsp_fault` are 0.
- R7: After reset, row i gives mode m the permission set P(i mod 4) when m + floor(i/4) >= 3, and no permission otherwise. The sets are P0 = read, P1 = read+fetch, P2 = read+write and P3 = read+write+fetch.
- R8: A table write on a rising edge (`cfg_wr_en`=1) governs requests accepted on later edges. A request accepted on the same edge uses the previous row contents.
- R9: A table write changes only the addressed row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Block can accept a request |
| req_present | input | 1 | Page-present flag from the page entry |
| req_acidx | input | 4 | Access-class index from the page entry |
| req_mode | input | 2 | Privilege mode carried by the operation |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_tag | input | 8 | Operation tag, returned unchanged |
| cfg_wr_en | input | 1 | Write one table row |
| cfg_wr_idx | input | 4 | Row to write |
| cfg_wr_data | input | 12 | New row contents |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 denied |
| rsp_tag | output | 8 | Tag of the answered request |

## Verification
The bench sweeps every row, mode and kind against the reset contents, then reprograms the table with irregular patterns, including write-only and fetch-only groups, and sweeps again. A design that swapped group order or bit order within a group would grant the wrong kind or mode in these sweeps. A design whose absent check lost priority to a permitting row would report allow for absent pages. The bench also issues a write and a request to the same row on one edge. A table read path that bypassed the write would answer with the new contents one request too early. A design that cleared neighbouring rows on a write would fail the sweep of rows left at their defaults.

// File: rtl/perm_pkg.sv
// Package: shared constants, cause codes and the reset contents of the
// permission table. Assumes four modes and three permission bits per mode.
package perm_pkg;
    parameter int LEVELS = 4;
    parameter int PERM_W = 3;
    parameter int ROWS   = 16;
    parameter int IDX_W  = $clog2(ROWS);
    parameter int MODE_W = $clog2(LEVELS);
    parameter int ROW_W  = LEVELS * PERM_W;

    // access kinds presented with a request
    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    // fault cause reported with a result
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_DENIED = 2'd2
    } cause_e;

    // permission group bit positions: read, write, fetch
    parameter int BIT_RD = 0;
    parameter int BIT_WR = 1;
    parameter int BIT_FE = 2;

    // one group pattern for each of the four meaningful permission sets
    function automatic logic [PERM_W-1:0] set_bits(input int sel);
        case (sel)
            0:       return 3'b001;   // read
            1:       return 3'b101;   // read + fetch
            2:       return 3'b011;   // read + write
            default: return 3'b111;   // read + write + fetch
        endcase
    endfunction

    // reset row: the lowest mode holding access drops as the index climbs
    function automatic logic [ROW_W-1:0] default_row(input int idx);
        logic [ROW_W-1:0] r;
        r = '0;
        for (int lvl = 0; lvl < LEVELS; lvl++) begin
            if (lvl + idx / 4 >= LEVELS - 1)
                r[lvl*PERM_W +: PERM_W] = set_bits(idx % 4);
        end
        return r;
    endfunction
endpackage

// File: rtl/perm_table.sv
// Permission table: ROWS registered rows with one write port and one
// asynchronous read port. Assumes a read in the write cycle sees old data.
module perm_table
    import perm_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    parameter int A_W    = $clog2(N_ROWS),
    parameter int D_W    = ROW_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_idx,
    input  logic [D_W-1:0] wr_data,
    input  logic [A_W-1:0] rd_idx,
    output logic [D_W-1:0] rd_data
);
    logic [D_W-1:0] rows_q [N_ROWS];

    // row storage: load defaults on reset, else take single-row writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ROWS; i++)
                rows_q[i] <= default_row(i);
        end else if (wr_en) begin
            rows_q[wr_idx] <= wr_data;
        end
    end

    // read port: plain index into the rows
    always_comb rd_data = rows_q[rd_idx];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && rst_n) |-> rows_q[$past(wr_idx)] == $past(wr_data)); // R8
endmodule

// File: rtl/perm_decide.sv
// Permission decision: picks the mode's group out of a table row and tests
// the bit matching the access kind. Pure combinational; absent page wins.
module perm_decide
    import perm_pkg::*;
#(
    parameter int N_LVL = LEVELS,
    parameter int G_W   = PERM_W,
    parameter int M_W   = $clog2(N_LVL)
) (
    input  logic [N_LVL*G_W-1:0] row,
    input  logic [M_W-1:0]       mode,
    input  logic [1:0]           kind,
    input  logic                 present,
    output logic                 allow,
    output logic [1:0]           cause
);
    logic [G_W-1:0] groups [N_LVL];
    logic [G_W-1:0] grp;
    logic           bit_ok;

    // slice the row into one group per mode
    for (genvar g = 0; g < N_LVL; g++) begin : g_split
        assign groups[g] = row[g*G_W +: G_W];
    end

    // mode mux
    always_comb grp = groups[mode];

    // kind to permission bit
    always_comb begin
        case (kind_e'(kind))
            KIND_READ:  bit_ok = grp[BIT_RD];
            KIND_WRITE: bit_ok = grp[BIT_WR];
            KIND_FETCH: bit_ok = grp[BIT_FE];
            default:    bit_ok = 1'b0;
        endcase
    end

    // verdict with absent-page priority
    always_comb begin
        if (!present) begin
            allow = 1'b0;
            cause = CAUSE_ABSENT;
        end else if (bit_ok) begin
            allow = 1'b1;
            cause = CAUSE_NONE;
        end else begin
            allow = 1'b0;
            cause = CAUSE_DENIED;
        end
    end
endmodule

// File: rtl/page_perm_check.sv
// Page permission checker top: accepts one request per cycle, looks up the
// access-class row, decides, and registers the verdict with its tag.
// Assumes the consumer always takes the result (no back-pressure).
module page_perm_check
    import perm_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_present,
    input  logic [IDX_W-1:0]  req_acidx,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [1:0]        req_kind,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_wr_idx,
    input  logic [ROW_W-1:0]  cfg_wr_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [TAG_W-1:0]  rsp_tag
);
    logic             ready_q;
    logic             accept;
    logic [ROW_W-1:0] row;
    logic             dec_allow;
    logic [1:0]       dec_cause;

    assign req_ready = ready_q;
    assign accept    = req_valid && ready_q;

    perm_table #(.N_ROWS(ROWS), .A_W(IDX_W), .D_W(ROW_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (req_acidx),
        .rd_data (row)
    );

    perm_decide #(.N_LVL(LEVELS), .G_W(PERM_W), .M_W(MODE_W)) u_decide (
        .row     (row),
        .mode    (req_mode),
        .kind    (req_kind),
        .present (req_present),
        .allow   (dec_allow),
        .cause   (dec_cause)
    );

    // ready comes up one edge after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // result register: verdict for the request accepted this edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
            rsp_tag   <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_allow <= dec_allow;
            rsp_fault <= !dec_allow;
            rsp_cause <= dec_cause;
            rsp_tag   <= req_tag;
        end else begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid); // R2
    AST_TAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_tag == $past(req_tag)); // R2
    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_present) |=> (rsp_fault && rsp_cause == CAUSE_ABSENT)); // R3
    AST_RSVD_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_present && req_kind == KIND_RSVD) |=> (rsp_fault && rsp_cause == CAUSE_DENIED)); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_allow && !rsp_fault); // R6
endmodule

// File: tb/test_page_perm_check.sv
module test_page_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_present = 1'b0;
    logic [3:0]  req_acidx = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_tag = '0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_idx = '0;
    logic [11:0] cfg_wr_data = '0;
    logic        rsp_valid, rsp_allow, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [7:0]  rsp_tag;

    int total = 0;
    int bad = 0;
    logic [11:0] model [16];

    always #10 clk = ~clk;

    page_perm_check i_page_perm_check (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_present(req_present), .req_acidx(req_acidx),
        .req_mode(req_mode), .req_kind(req_kind), .req_tag(req_tag),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_tag(rsp_tag)
    );

    // R7 reset contents, computed group by group
    function automatic logic [11:0] reset_row(input int r);
        logic [11:0] v = '0;
        logic [2:0]  s;
        case (r & 3)
            0: s = 3'b001;
            1: s = 3'b101;
            2: s = 3'b011;
            default: s = 3'b111;
        endcase
        for (int m = 0; m < 4; m++)
            if (m + (r >> 2) >= 3) v = v | (12'(s) << (3 * m));
        return v;
    endfunction

    // R4/R5 expected permission bit
    function automatic logic want_bit(input logic [11:0] row, input int m, input int k);
        logic [2:0] g = 3'((row >> (3 * m)) & 12'h7);
        if (k == 3) return 1'b0;
        return g[k];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one request; called at a negedge, returns at a negedge
    task automatic one_req(input string req, input logic pres, input int idx,
                           input int m, input int k, input logic [7:0] tg,
                           input logic [11:0] row_exp);
        logic ok;
        logic [1:0] cause;
        req_valid = 1'b1; req_present = pres; req_acidx = 4'(idx);
        req_mode = 2'(m); req_kind = 2'(k); req_tag = tg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ok = pres && want_bit(row_exp, m, k);
        cause = !pres ? 2'd1 : (ok ? 2'd0 : 2'd2);
        check(req, {rsp_valid, rsp_allow, rsp_fault, rsp_cause, rsp_tag},
                   {1'b1, ok, !ok, cause, tg});
    endtask

    task automatic wr_row(input int idx, input logic [11:0] d);
        cfg_wr_en = 1'b1; cfg_wr_idx = 4'(idx); cfg_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model[idx] = d;
    endtask

    task automatic sweep(input string req);
        for (int r = 0; r < 16; r++)
            for (int m = 0; m < 4; m++)
                for (int k = 0; k < 4; k++)
                    one_req(req, 1'b1, r, m, k, 8'(r * 16 + m * 4 + k), model[r]);
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) model[r] = reset_row(r);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready in reset", 32'(req_ready), 32'd0);
        check("R1 valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 ready after reset", 32'(req_ready), 32'd1);
        check("R2 idle no response", 32'(rsp_valid), 32'd0);

        // R7 R4 R5 R6 defaults, full sweep
        sweep("R7 default sweep");
        // R3 absent pages, even on fully open rows
        for (int r = 0; r < 16; r++)
            one_req("R3 absent", 1'b0, r, 3, r & 3, 8'(200 + r), model[r]);
        // R2 idle cycle after response
        @(negedge clk);
        check("R2 single-cycle response", 32'(rsp_valid), 32'd0);

        // R9 rewrite even rows only, odd rows must keep defaults
        for (int r = 0; r < 16; r += 2)
            wr_row(r, 12'((r * 12'h2C9) ^ 12'hA5F));
        sweep("R9 partial rewrite sweep");
        // R4 R5 isolated single-bit groups
        wr_row(1, 12'b010_000_000_000);
        wr_row(3, 12'b000_100_000_000);
        wr_row(5, 12'b000_000_001_000);
        sweep("R4 single-bit sweep");

        // R8 write and request on the same edge: old row applies
        cfg_wr_en = 1'b1; cfg_wr_idx = 4'd7; cfg_wr_data = 12'h000;
        one_req("R8 same-edge old data", 1'b1, 7, 3, 0, 8'hE1, model[7]);
        cfg_wr_en = 1'b0;
        model[7] = 12'h000;
        one_req("R8 next request new data", 1'b1, 7, 3, 0, 8'hE2, model[7]);
        wr_row(7, 12'hFFF);
        one_req("R8 reopened row", 1'b1, 7, 0, 1, 8'hE3, model[7]);

        // R1 reset restores defaults
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++) model[r] = reset_row(r);
        @(posedge clk);
        @(negedge clk);
        sweep("R7 defaults after second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule